// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Permissions

This block keeps recently used virtual-to-physical page mappings close to a processor pipeline. A lookup presents a virtual address together with an access kind (load or store). The virtual page number is compared against every stored entry at once. One cycle later the block reports one of three outcomes: a hit with the translated physical address, a miss when no valid entry matches, or a permission fault when an entry matches but does not allow the requested kind of access.

Entries are installed through a separate fill port, driven by software or by an external table walker. Each fill carries the page number, the frame number and two permission flags. A fill whose page number is already cached rewrites that entry in place. Any other fill goes into the slot chosen by a round-robin pointer. A flush input invalidates the whole table in a single cycle. Pages are 8 KB, so the low 13 address bits bypass translation. With the default parameters the table has 32 entries, a 43-bit virtual address and a 34-bit physical address.

Top module: `xlate_cache`

## Requirements
- R1: After reset `rsp_valid` is 0 and no entry is valid, so the first lookup reports a miss.
- R2: A lookup whose page number matches a valid entry that permits the access sets `rsp_hit` one cycle later. `rsp_paddr` is then the entry's 21-bit frame number in bits 33:13, and the lookup's address bits 12:0 in bits 12:0.
- R3: A lookup with no valid matching entry sets `rsp_miss` one cycle later, with `rsp_paddr` equal to 0.
- R4: A matching entry is checked against the permission for the access kind. `lk_write`=0 checks the read flag and `lk_write`=1 checks the write flag. If that flag is 0, the block sets `rsp_fault` and `rsp_paddr` is 0.
- R5: A fill whose page number matches a valid entry rewrites that entry's frame number and permissions, evicts nothing and leaves the round-robin pointer where it was.
- R6: A fill with a new page number writes the slot under the round-robin pointer and then advances the pointer by one. The pointer is 0 after reset and wraps from the last slot to 0, so the 33rd new fill evicts the first one.
- R7: `flush` invalidates every entry in one cycle and returns the pointer to 0. A fill in the same cycle as a flush is dropped.
- R8: A lookup sees the table as it was before the clock edge, so a fill or flush in the same cycle does not affect that lookup's result.
- R9: When `rsp_valid` is 1, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is 1. When `rsp_valid` is 0, all three flags are 0.
- R10: `rsp_valid` equals `lk_valid` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 43 | Virtual address to translate |
| lk_write | input | 1 | 1 = store access, 0 = load access |
| fill_valid | input | 1 | Install an entry |
| fill_vpn | input | 30 | Virtual page number to install |
| fill_pfn | input | 21 | Physical frame number to install |
| fill_rd_ok | input | 1 | Loads permitted |
| fill_wr_ok | input | 1 | Stores permitted |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_fault | output | 1 | Entry matched but access not permitted |
| rsp_paddr | output | 34 | Physical address on a hit, else 0 |

## Verification
A lookup can share a cycle with a fill or with a flush. The lookup must see the table as it was before the edge, while the update lands at that same edge. The bench provokes this in three ways: it fills a page while looking it up, it flushes while looking up a cached page, and it issues a flush and a fill together. It judges each case by the outcome of that lookup and of the lookup in the following cycle. A long mixed sweep over a small range of page numbers also lands fills, flushes and lookups in the same cycles, and compares every response with a reference table that the bench keeps.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } perm_t;

  function automatic logic perm_allows(perm_t p, logic is_store);
    return is_store ? p.wr : p.rd;
  endfunction
endpackage

// File: rtl/xlate_match.sv
module xlate_match #(
  parameter int N     = 32,
  parameter int TAG_W = 30
) (
  input  logic [TAG_W-1:0] tags  [N],
  input  logic [N-1:0]     vld,
  input  logic [TAG_W-1:0] key,
  output logic [N-1:0]     hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (tags[i] == key);
  end
endmodule

// File: rtl/xlate_select.sv
module xlate_select #(
  parameter int N = 32,
  parameter int W = 23
) (
  input  logic [N-1:0] sel,
  input  logic [W-1:0] data [N],
  output logic [W-1:0] out
);
  always_comb begin
    out = '0;
    for (int i = 0; i < N; i++) begin
      out = out | (data[i] & {W{sel[i]}});
    end
  end
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ptr <= '0;
    end else if (advance) begin
      if (ptr == IDX_W'(N - 1)) ptr <= '0;
      else                      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
  parameter int ENTRIES  = 32,
  parameter int OFFSET_W = 13,
  parameter int VPN_W    = 30,
  parameter int PFN_W    = 21,
  localparam int VA_W    = VPN_W + OFFSET_W,
  localparam int PA_W    = PFN_W + OFFSET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_rd_ok,
  input  logic              fill_wr_ok,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr
);
  import xlate_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PAY_W = PFN_W + $bits(perm_t);

  // Table storage: tag and payload carry no reset, only valid bits do.
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PAY_W-1:0]   pay_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [ENTRIES-1:0] lk_hits, fill_hits;
  logic [PAY_W-1:0]   lk_pay;
  logic [IDX_W-1:0]   rr_ptr;
  logic               fill_known, fill_go, fill_new;

  xlate_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_match (
    .tags(tag_q), .vld(vld_q), .key(lk_vaddr[VA_W-1:OFFSET_W]), .hit_vec(lk_hits)
  );

  xlate_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_fill_match (
    .tags(tag_q), .vld(vld_q), .key(fill_vpn), .hit_vec(fill_hits)
  );

  xlate_select #(.N(ENTRIES), .W(PAY_W)) u_sel (
    .sel(lk_hits), .data(pay_q), .out(lk_pay)
  );

  assign fill_known = |fill_hits;
  assign fill_go    = fill_valid && !flush;
  assign fill_new   = fill_go && !fill_known;

  xlate_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .clear(flush), .advance(fill_new), .ptr(rr_ptr)
  );

  perm_t fill_perm;
  assign fill_perm = '{rd: fill_rd_ok, wr: fill_wr_ok};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic we;
    assign we = fill_go && (fill_known ? fill_hits[i] : (rr_ptr == IDX_W'(i)));

    always_ff @(posedge clk) begin
      if (we) begin
        tag_q[i] <= fill_vpn;
        pay_q[i] <= {fill_pfn, fill_perm};
      end
    end

    always_ff @(posedge clk) begin
      if (rst || flush) vld_q[i] <= 1'b0;
      else if (we)      vld_q[i] <= 1'b1;
    end
  end

  // Registered lookup result.
  perm_t            lk_perm;
  logic [PFN_W-1:0] lk_pfn;
  logic             lk_any, lk_ok;

  assign {lk_pfn, lk_perm} = lk_pay;
  assign lk_any = |lk_hits;
  assign lk_ok  = perm_allows(lk_perm, lk_write);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_any && lk_ok;
      rsp_miss  <= lk_valid && !lk_any;
      rsp_fault <= lk_valid && lk_any && !lk_ok;
      rsp_paddr <= (lk_valid && lk_any && lk_ok)
                   ? {lk_pfn, lk_vaddr[OFFSET_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int OFFSET_W = 13,
  parameter int PA_W     = 34
) (
  input logic                clk,
  input logic                rst,
  input logic                flush,
  input logic                lk_valid,
  input logic [OFFSET_W-1:0] lk_off,
  input logic                rsp_valid,
  input logic                rsp_hit,
  input logic                rsp_miss,
  input logic                rsp_fault,
  input logic [PA_W-1:0]     rsp_paddr
);
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (!rsp_hit || rsp_paddr[OFFSET_W-1:0] == $past(lk_off)));

  assert_paddr_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> rsp_paddr == '0);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    flush ##1 lk_valid |=> rsp_miss);
endmodule

bind xlate_cache xlate_cache_chk #(.OFFSET_W(OFFSET_W), .PA_W(PA_W)) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid),
  .lk_off(lk_vaddr[OFFSET_W-1:0]),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/xlate_cache_tb_top.sv
module xlate_cache_tb_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst, flush, lk_valid, lk_write, fill_valid, fill_rd_ok, fill_wr_ok;
  logic [42:0] lk_vaddr;
  logic [29:0] fill_vpn;
  logic [20:0] fill_pfn;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [33:0] rsp_paddr;

  always #4 clk = ~clk;  // 125 MHz

  xlate_cache dut_i (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_rd_ok(fill_rd_ok), .fill_wr_ok(fill_wr_ok),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Reference table
  logic [29:0] r_vpn [N];
  logic [20:0] r_pfn [N];
  bit          r_v [N], r_rd [N], r_wr [N];
  int          r_ptr;

  task automatic ref_clear();
    for (int i = 0; i < N; i++) r_v[i] = 0;
    r_ptr = 0;
  endtask

  task automatic compare(string tag, logic [37:0] got, logic [37:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got v/h/m/f/pa=%h expected %h", tag, got, exp);
    end
  endtask

  // One cycle: called at a negedge, returns at the next negedge after checking.
  task automatic cycle(string tag, bit lv, logic [42:0] va, bit lw,
                       bit fv, logic [29:0] fvpn, logic [20:0] fpfn,
                       bit frd, bit fwr, bit fl);
    logic [37:0] exp;
    int j;
    exp = '0;
    if (lv) begin
      exp[37] = 1'b1;
      j = -1;
      for (int i = 0; i < N; i++) if (r_v[i] && r_vpn[i] == va[42:13]) j = i;
      if (j < 0) exp[35] = 1'b1;
      else if (lw ? r_wr[j] : r_rd[j]) begin
        exp[36] = 1'b1;
        exp[33:0] = {r_pfn[j], va[12:0]};
      end else exp[34] = 1'b1;
    end
    lk_valid = lv; lk_vaddr = va; lk_write = lw;
    fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn;
    fill_rd_ok = frd; fill_wr_ok = fwr; flush = fl;
    @(posedge clk);
    if (fl) ref_clear();
    else if (fv) begin
      j = -1;
      for (int i = 0; i < N; i++) if (r_v[i] && r_vpn[i] == fvpn) j = i;
      if (j < 0) begin j = r_ptr; r_ptr = (r_ptr + 1) % N; end
      r_v[j] = 1; r_vpn[j] = fvpn; r_pfn[j] = fpfn; r_rd[j] = frd; r_wr[j] = fwr;
    end
    @(negedge clk);
    compare(tag, {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr}, exp);
  endtask

  task automatic fill(string tag, logic [29:0] vpn, logic [20:0] pfn, bit rd, bit wr);
    cycle(tag, 0, '0, 0, 1, vpn, pfn, rd, wr, 0);
  endtask

  task automatic look(string tag, logic [29:0] vpn, logic [12:0] off, bit wr);
    cycle(tag, 1, {vpn, off}, wr, 0, '0, '0, 0, 0, 0);
  endtask

  initial begin
    rst = 1; flush = 0; lk_valid = 0; lk_vaddr = '0; lk_write = 0;
    fill_valid = 0; fill_vpn = '0; fill_pfn = '0; fill_rd_ok = 0; fill_wr_ok = 0;
    ref_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset", {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr}, '0);
    rst = 0;
    look("R1 empty lookup", 30'd3, 13'h0, 0);

    // R2/R4: fill the whole table with mixed permissions, probe loads and stores
    for (int i = 0; i < N; i++)
      fill("R6 fill", 30'(i * 7 + 3), 21'(i * 1000 + 5), (i % 3) != 0, (i % 2) == 0);
    for (int i = 0; i < N; i++) begin
      look("R2/R4 load", 30'(i * 7 + 3), 13'(i * 251), 0);
      look("R2/R4 store", 30'(i * 7 + 3), 13'h1fff - 13'(i), 1);
    end
    look("R3 absent page", 30'd4, 13'h55, 0);
    look("R3 high page", 30'h3fffffff, 13'h1fff, 1);

    // R6: 33rd new page evicts slot 0 and keeps slot 1
    fill("R6 wrap fill", 30'd900, 21'h1abcde, 1, 1);
    look("R6 evicted first", 30'd3, 13'h10, 0);
    look("R6 second kept", 30'd10, 13'h10, 1);
    look("R6 new entry", 30'd900, 13'h1234, 1);

    // R5: overwrite in place, nothing else lost
    fill("R5 overwrite", 30'(3 * 7 + 3), 21'h0f0f0, 1, 1);
    for (int i = 1; i < N; i++) look("R5 intact", 30'(i * 7 + 3), 13'h7, 1);
    fill("R5 pointer held", 30'd901, 21'h22, 1, 0);
    look("R5 pointer held", 30'd10, 13'h0, 0);

    // R8: fill and lookup of the same page in one cycle
    cycle("R8 lookup with fill", 1, {30'd777, 13'h3}, 0, 1, 30'd777, 21'h777, 1, 1, 0);
    look("R8 after fill", 30'd777, 13'h3, 0);

    // R7/R8: flush with lookup, then flush with fill
    cycle("R8 lookup with flush", 1, {30'd777, 13'h9}, 1, 0, '0, '0, 0, 0, 1);
    look("R7 after flush", 30'd777, 13'h9, 1);
    cycle("R7 fill dropped", 0, '0, 0, 1, 30'd55, 21'h55, 1, 1, 1);
    look("R7 fill dropped", 30'd55, 13'h0, 0);
    for (int i = 0; i < N + 1; i++) fill("R7 refill", 30'(2000 + i), 21'(i), 1, 1);
    look("R7 pointer cleared", 30'd2000, 13'h0, 0);
    look("R7 pointer cleared", 30'd2001, 13'h0, 0);

    // Mixed sweep over a small page range
    for (int k = 0; k < 4000; k++) begin
      bit lv, fv, fl;
      logic [31:0] r;
      r  = $urandom;
      lv = r[0] | r[1];
      fv = r[2] & r[3];
      fl = (r[9:4] == 6'd0);
      cycle("R9 sweep", lv, {30'(r[15:10] % 40), r[28:16]}, r[29],
            fv, 30'($urandom % 40), 21'($urandom), r[30], r[31], fl);
    end
    cycle("R10 idle", 0, '0, 0, 0, '0, '0, 0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule